// File: doc/BRIEF.md
# Interrupt Priority Encoder and Acknowledge Decoder

This block sits between seven peripheral interrupt request lines and a processor that takes its pending interrupt level as three encoded, active-low level lines. The requests are active low and numbered 1 to 7. The block picks the highest-numbered request that is active and presents its number on the level lines. The level lines come from a register, so a request pattern that changes between clock edges cannot make them glitch. An encoded level of 0 means that nothing is pending. The processor's comparison of this level against its interrupt mask is outside the block.

When the processor accepts an interrupt, it runs an acknowledge bus cycle. The block recognises this cycle from three things together:
- the function code is 111,
- the address strobe is low,
- address bits 23 down to 4 are all ones.

Address bits 3 to 1 then carry the level being serviced. The block drives low the single acknowledge line for that level. The peripheral that owns that level answers by placing its 8-bit vector number on data bits 7 to 0.

Top module: `irq_level_ack`

## Requirements
- R1: While rst_n is low, ipl_n reads 3'b111 (level 0).
- R2: After each rising clock edge, ipl_n equals the bitwise inverse of the highest index k (1..7) for which irq_n[k] was 0 at that edge. If no request was active, ipl_n is 3'b111.
- R3: ipl_n changes only at rising clock edges. A change on irq_n between edges leaves ipl_n unchanged until the next edge.
- R4: A request on irq_n[7] yields ipl_n = 3'b000 whatever the other request lines are doing.
- R5: When fc = 3'b111, as_n = 0, addr[23:4] are all ones and addr[3:1] = k with k from 1 to 7, iack_n[k] is 0 and every other iack_n bit is 1.
- R6: At most one bit of iack_n is 0 at any time.
- R7: While as_n is 1, every bit of iack_n is 1.
- R8: When fc is any value other than 3'b111, every bit of iack_n is 1.
- R9: When addr[3:1] = 0, or any bit of addr[23:4] is 0, every bit of iack_n is 1, even during an acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the level register |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 7 | Active-low requests; bit k is level k (index 7:1) |
| ipl_n | output | 3 | Registered, inverted encoded pending level |
| fc | input | 3 | Processor function code |
| as_n | input | 1 | Active-low address strobe |
| addr | input | 23 | Processor address bits 23 to 1 |
| iack_n | output | 7 | Active-low acknowledge per level (index 7:1) |

## Verification
The hardest case to reach is a request pattern that changes between clock edges. Only that case shows whether the level output is truly registered or is instead following the requests through logic. The stimulus changes irq_n half a period before a rising edge and samples ipl_n before that edge. It then samples ipl_n again after the edge.

Acknowledge decoding is swept over every function code, every address level and both strobe states. The bench also clears each upper address bit in turn, so that an acknowledge cycle with a malformed address is tried for every bit position.

// File: rtl/irq_level_ack.sv
module irq_level_ack #(
  parameter int ADDR_HI = 23
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:1]     irq_n,
  output logic [2:0]     ipl_n,
  input  logic [2:0]     fc,
  input  logic           as_n,
  input  logic [ADDR_HI:1] addr,
  output logic [7:1]     iack_n
);

  localparam logic [2:0] FC_ACK = 3'b111;

  logic [2:0] top_lvl;
  logic       ack_cyc;

  always_comb begin
    top_lvl = 3'd0;
    for (int i = 1; i <= 7; i++)
      if (!irq_n[i]) top_lvl = 3'(i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ipl_n <= 3'b111;
    else        ipl_n <= ~top_lvl;

  assign ack_cyc = (fc == FC_ACK) && !as_n && (&addr[ADDR_HI:4]);

  for (genvar k = 1; k <= 7; k++) begin : g_ack
    assign iack_n[k] = !(ack_cyc && addr[3:1] == 3'(k));
  end

  // R4
  lvl7_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n[7] |=> ipl_n == 3'b000);

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_n) |=> ipl_n == 3'b111);

  // R6
  single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~iack_n) <= 1);

  // R7
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> &iack_n);

  // R8
  fc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fc != FC_ACK |-> &iack_n);

endmodule

// File: tb/irq_level_ack_tb_top.sv
module irq_level_ack_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:1]  irq_n = '1;
  logic [2:0]  ipl_n;
  logic [2:0]  fc = 3'b001;
  logic        as_n = 1;
  logic [23:1] addr = '0;
  logic [7:1]  iack_n;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_level_ack dut_i (.clk(clk), .rst_n(rst_n), .irq_n(irq_n), .ipl_n(ipl_n),
    .fc(fc), .as_n(as_n), .addr(addr), .iack_n(iack_n));

  function automatic logic [2:0] exp_ipl(logic [7:1] r);
    logic [2:0] l = 0;
    for (int i = 1; i <= 7; i++) if (!r[i]) l = 3'(i);
    return ~l;
  endfunction

  function automatic logic [7:1] exp_ack(logic [2:0] f, logic s, logic [23:1] a);
    logic [7:1] v = '1;
    if (f == 3'd7 && !s && (&a[23:4]) && a[3:1] != 0) v[a[3:1]] = 1'b0;
    return v;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    irq_n = 7'b0000000;
    repeat (2) @(negedge clk);
    chk("R1 reset level", {5'd0, ipl_n}, 8'h07);
    rst_n = 1;
    // R2 R4: all 128 request patterns
    for (int p = 0; p < 128; p++) begin
      @(negedge clk);
      irq_n = 7'(p);
      @(negedge clk);
      chk(irq_n[7] ? "R2 encode" : "R4 level7", {5'd0, ipl_n}, {5'd0, exp_ipl(7'(p))});
    end
    // R3: change between edges
    for (int p = 1; p < 128; p += 9) begin
      @(negedge clk);
      irq_n = 7'(p);
      @(negedge clk);
      irq_n = ~irq_n;
      #5;
      chk("R3 held", {5'd0, ipl_n}, {5'd0, exp_ipl(7'(p))});
      @(negedge clk);
      chk("R3 update", {5'd0, ipl_n}, {5'd0, exp_ipl(~7'(p))});
    end
    // R5 R7 R8 R9: acknowledge sweep
    for (int f = 0; f < 8; f++)
      for (int l = 0; l < 8; l++)
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          fc = 3'(f); as_n = s[0];
          addr = {20'hFFFFF, 3'(l)};
          #2;
          chk(f != 7 ? "R8 fc" : s != 0 ? "R7 strobe" : l == 0 ? "R9 level0" : "R5 ack",
              {1'b0, iack_n}, {1'b0, exp_ack(fc, as_n, addr)});
          chk("R6 single", {4'd0, 4'($countones(~iack_n))}, {4'd0, 4'($countones(~exp_ack(fc, as_n, addr)))});
        end
    for (int b = 4; b <= 23; b++)
      for (int l = 1; l < 8; l += 3) begin
        @(negedge clk);
        fc = 3'd7; as_n = 0;
        addr = {20'hFFFFF, 3'(l)};
        addr[b] = 1'b0;
        #2;
        chk("R9 upper bits", {1'b0, iack_n}, 8'h7F);
      end
    as_n = 1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule